// File: doc/BRIEF.md
# Oscillator wake-up delay timer

This block keeps the core clock gated off after reset or after a wake from power-down, until the selected oscillator has had time to settle. It runs on the oscillator clock and takes a one-cycle microsecond tick from a free-running time reference. It also takes a 3-bit code for the clock source and a start pulse.

The wait depends on the source code that is sampled at start:

- Crystal sources wait a number of oscillator cycles, then a further window measured in microsecond ticks.
- The internal RC source waits only a microsecond window.
- The watchdog oscillator and an external clock wait a short cycle count only.

When the wait is over, the block raises a ready flag that opens the core clock gate. The flag stays high until the next start or reset.

Top module: `osc_wake_timer`

## Requirements
- R1: After reset `clk_ready` is 0, and it stays 0 until a start pulse has been given and the wait for its source has finished.
- R2: An edge that samples `start` = 1 makes `clk_ready` 0 after that edge. The same edge captures `src_sel` as the source for the new wait.
- R3: Codes 0, 1 and 2 are crystal sources. Take the start edge as edge 0. The first 1024 edges after it (`XTAL_CYCLES`) are a cycle phase. After that, each edge that samples `us_tick` = 1 counts once. `clk_ready` goes to 1 right after the edge that counts the 80th tick (`XTAL_TAIL_US`).
- R4: Code 3 is the RC source. There is no cycle phase. `clk_ready` goes to 1 right after the edge that samples the 256th `us_tick` (`RC_US`) following the start edge.
- R5: Codes 4 (watchdog oscillator) and 5 (external clock) wait for cycles only. `clk_ready` goes to 1 right after edge 32 (`SHORT_CYCLES`) counted from the start edge, whatever `us_tick` does.
- R6: Codes 6 and 7 behave exactly like code 5.
- R7: A start pulse during a wait abandons that wait. The new wait is timed from the new start edge, with the newly sampled code.
- R8: Changes to `src_sel` after the start edge do not change the length of the wait that is running.
- R9: Once high, `clk_ready` stays high until the next start or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| start | input | 1 | Begins, or restarts, a wait |
| src_sel | input | 3 | Clock source code: 0-2 crystal, 3 RC, 4 watchdog oscillator, 5-7 external |
| clk_ready | output | 1 | High when the core clock may run |

## Verification
If the state is wrong, the result shows at the port as a `clk_ready` edge in the wrong cycle. The bench measures the exact edge at which `clk_ready` rises and compares it with an edge count it computes on its own from the tick pattern it drives.

- A wrong count limit, or a skipped or extra phase, moves the rise by at least one cycle within one wait length.
- A wrong source latch shows up as a wait of entirely the wrong length.
- A failed restart shows up as a rise that is timed from the old start edge.

// File: rtl/osc_wake_timer.sv
module osc_wake_timer #(
  parameter int XTAL_CYCLES  = 1024,
  parameter int SHORT_CYCLES = 32,
  parameter int XTAL_TAIL_US = 80,
  parameter int RC_US        = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       start,
  input  logic [2:0] src_sel,
  output logic       clk_ready
);
  localparam int MAX_A = (XTAL_CYCLES > SHORT_CYCLES) ? XTAL_CYCLES : SHORT_CYCLES;
  localparam int MAX_B = (XTAL_TAIL_US > RC_US) ? XTAL_TAIL_US : RC_US;
  localparam int MAXV  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXV + 1);

  typedef enum logic [1:0] {IDLE, CYCLES, TIME, READY} st_t;

  st_t           state;
  logic [2:0]    sel_q;
  logic [CW-1:0] cnt;

  wire is_xtal = (sel_q <= 3'd2);
  wire is_rc   = (sel_q == 3'd3);
  wire new_rc  = (src_sel == 3'd3);

  wire [CW-1:0] cyc_lim  = is_xtal ? CW'(XTAL_CYCLES - 1) : CW'(SHORT_CYCLES - 1);
  wire [CW-1:0] time_lim = is_xtal ? CW'(XTAL_TAIL_US - 1) : CW'(RC_US - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      sel_q <= 3'd0;
      cnt   <= '0;
    end else if (start) begin
      sel_q <= src_sel;
      cnt   <= '0;
      state <= new_rc ? TIME : CYCLES;
    end else begin
      case (state)
        CYCLES:
          if (cnt == cyc_lim) begin
            cnt   <= '0;
            state <= is_xtal ? TIME : READY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        TIME:
          if (us_tick) begin
            if (cnt == time_lim) begin
              cnt   <= '0;
              state <= READY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        default: ;
      endcase
    end
  end

  assign clk_ready = (state == READY);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !clk_ready);
  a_r9_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ready && !start) |=> clk_ready);
  a_r1_no_rise_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_ready) |-> !$past(start));
  a_r4_rc_skips_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CYCLES) |-> !is_rc);
  a_r5_time_only_xtal_rc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TIME) |-> (is_xtal || is_rc));
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CYCLES) |-> (cnt <= cyc_lim));
endmodule

// File: tb/osc_wake_timer_tb.sv
module osc_wake_timer_tb;
  localparam int PERIOD   = 10;
  localparam int TICK_DIV = 5;
  localparam int XC = 1024, SC = 32, XT = 80, RT = 256;

  logic clk = 0, rst_n = 0, us_tick = 0, start = 0;
  logic [2:0] src_sel = 0;
  logic clk_ready;
  int checks = 0, errors = 0;
  int tdiv = 0;

  osc_wake_timer u_dut (.clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
                        .src_sel(src_sel), .clk_ready(clk_ready));

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    us_tick <= (tdiv == TICK_DIV - 1);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [2:0] sel);
    @(negedge clk);
    src_sel = sel;
    start   = 1;
    @(negedge clk);
    start   = 0;
  endtask

  // After pulse_start, sits at the negedge following the start edge (edge 0).
  task automatic measure(input string req, input int cyc, input int tim,
                         input logic [2:0] later_sel);
    int n = 0, tcount = 0, exp_edge = 0, got_edge = 0;
    logic tk;
    src_sel = later_sel;
    while ((exp_edge == 0 || got_edge == 0) && n < 6000) begin
      if (got_edge == 0 && clk_ready) got_edge = n;
      if (got_edge == 0 && n == 0 && clk_ready) got_edge = -1;
      tk = us_tick;
      if (tim > 0 && n + 1 > cyc && tk) tcount++;
      if (exp_edge == 0 && ((tim == 0 && n + 1 == cyc) || (tim > 0 && tcount == tim)))
        exp_edge = n + 1;
      @(negedge clk);
      n++;
    end
    if (got_edge == 0 && clk_ready) got_edge = n;
    check(req, got_edge, exp_edge);
  endtask

  task automatic t_reset;
    check("R1 reset ready", clk_ready, 0);
    repeat (50) @(negedge clk);
    check("R1 no start stays low", clk_ready, 0);
  endtask

  task automatic t_codes;
    for (int c = 0; c < 8; c++) begin
      pulse_start(3'(c));
      if (c <= 2)      measure("R3 crystal wait", XC, XT, 3'(c));
      else if (c == 3) measure("R4 rc wait", 0, RT, 3'(c));
      else if (c <= 5) measure("R5 short wait", SC, 0, 3'(c));
      else             measure("R6 other code as external", SC, 0, 3'(c));
    end
  endtask

  task automatic t_restart;
    pulse_start(3'd5);
    repeat (10) @(negedge clk);
    pulse_start(3'd3);
    measure("R7 restart uses new start", 0, RT, 3'd3);
  endtask

  task automatic t_ignore_sel;
    pulse_start(3'd5);
    measure("R8 select change ignored", SC, 0, 3'd3);
  endtask

  task automatic t_clear_hold;
    repeat (20) @(negedge clk);
    check("R9 ready held", clk_ready, 1);
    pulse_start(3'd4);
    check("R2 start clears ready", clk_ready, 0);
    measure("R2 new wait after clear", SC, 0, 3'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_codes();
    t_restart();
    t_ignore_sel();
    t_clear_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule